// File: doc/BRIEF.md
# Dual-Mode Down-Counter/Timer

This block is a parameterised down-counter (16 bits by default) with a programmable preload value and two modes of operation, picked when the counter is started. In one-shot mode a start command copies the preload into the counter, which then counts down by one every clock. When the count passes from one to zero, a sticky interrupt flag is set. The counter keeps running through zero into the all-ones value, so software can still read how much time has passed. This makes the mode usable as a single-interrupt generator, a stopwatch or a watchdog.

In periodic mode the counter reloads itself from the preload each time it reaches its terminal count. At every reload it toggles a square-wave output, so the output period is twice the preload in input clocks. The square wave can drive the bit clock of serial channels, and the reloads give periodic interrupts. A preload of zero stands for 2^CNT_W. A stop command freezes the count. Reads of the count go through a snapshot register that is filled in a single cycle, so the value read is always consistent.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, count_o, irq_o and sqw_o are all 0 and the counter is stopped.
- R2: A start command (start_i high with stop_i low) loads the stored preload into the counter. While running, the counter then drops by exactly one on every clock.
- R3: In one-shot mode (mode_i = 0 at start), a preload of N sets the interrupt flag on the Nth clock after the start edge. The count then goes on from zero to all-ones and keeps decrementing.
- R4: In periodic mode (mode_i = 1 at start), on the clock where the count is 1 the counter reloads from the preload instead of reaching zero, and sqw_o toggles. With a preload of N, sqw_o therefore toggles every N clocks.
- R5: A preload of zero behaves as 2^CNT_W, both for the one-shot terminal count and for the periodic half-period.
- R6: stop_i freezes the count and stops the counter. When start_i and stop_i are high together, stop wins and the count stays frozen.
- R7: The interrupt flag stays set until irq_clr_i is high. A terminal count in the same cycle as a clear wins over the clear. irq_o is the flag gated by irq_en_i, and the flag is kept while irq_en_i is low.
- R8: On a clock with rd_i high, count_o takes the count value held just before that edge. On any other clock, count_o holds its value.
- R9: A preload write while running does not change the current count. The new value is used from the next reload onward.
- R10: Changing mode_i while running has no effect until the next start.
- R11: In one-shot mode sqw_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_we_i | input | 1 | Preload write strobe |
| pre_val_i | input | CNT_W | Preload value (0 means 2^CNT_W) |
| mode_i | input | 1 | 0 one-shot, 1 periodic; sampled at start |
| start_i | input | 1 | Start command: load preload and run |
| stop_i | input | 1 | Stop command: freeze count |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| rd_i | input | 1 | Capture current count into count_o |
| count_o | output | CNT_W | Captured count value |
| irq_o | output | 1 | Interrupt, flag gated by enable |
| sqw_o | output | 1 | Square-wave output (periodic mode) |

## Verification
The bench builds the block with CNT_W = 8. With that width, the wrap from zero to all-ones and the zero-preload case (256 clocks) can be reached in a few hundred cycles, including a full half-period of the square wave. The default width of 16 is used only for elaboration. A scoreboard predicts each captured count, flag and wave level from the preload, the mode and the number of clocks since start, and checks them together with the measured square-wave half-periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  tmr_mode_e mode_i,
  output logic      load_o,
  output logic      run_o,
  output tmr_mode_e mode_o
);
  // stop has priority over start
  assign load_o = start_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      mode_o <= MODE_ONESHOT;
    end else if (stop_i) begin
      run_o  <= 1'b0;
    end else if (start_i) begin
      run_o  <= 1'b1;
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/tmr_down.sv
module tmr_down
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             stop_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dec;

  assign dec    = run_i & ~stop_i & ~load_i;
  // terminal at 1->0 step, so a zero preload spans 2^CNT_W clocks
  assign term_o = dec & (cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= pre_i;
    end else if (dec) begin
      if (term_o && mode_i == MODE_PERIODIC) cnt_o <= pre_i;
      else                                   cnt_o <= cnt_o - ONE;
    end
  end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      term_i,
  input  tmr_mode_e mode_i,
  output logic      sqw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                sqw_o <= 1'b0;
    else if (load_i)                            sqw_o <= 1'b0;
    else if (term_i && mode_i == MODE_PERIODIC) sqw_o <= ~sqw_o;
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o & en_i;
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_we_i,
  input  logic [CNT_W-1:0] pre_val_i,
  input  logic             mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             sqw_o
);
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             run;
  logic             term;
  logic             flag;
  tmr_mode_e        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (pre_we_i) pre_q <= pre_val_i;
  end

  tmr_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .mode_i  (tmr_mode_e'(mode_i)),
    .load_o  (load),
    .run_o   (run),
    .mode_o  (mode_q)
  );

  tmr_down #(.CNT_W(CNT_W)) u_down (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (run),
    .stop_i (stop_i),
    .mode_i (mode_q),
    .pre_i  (pre_q),
    .cnt_o  (cnt),
    .term_o (term)
  );

  tmr_wave u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .term_i (term),
    .mode_i (mode_q),
    .sqw_o  (sqw_o)
  );

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (term),
    .clr_i  (irq_clr_i),
    .en_i   (irq_en_i),
    .flag_o (flag),
    .irq_o  (irq_o)
  );

  // single-cycle snapshot for coherent reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   count_o <= '0;
    else if (rd_i) count_o <= cnt;
  end
endmodule

module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             rd_i,
  input logic             irq_clr_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             sqw_o,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             run,
  input tmr_mode_e        mode_q
);
  // R2
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !stop_i && !start_i && cnt != CNT_W'(1)) |=> cnt == $past(cnt) - CNT_W'(1));

  // R6
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> ($stable(cnt) && !run));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !irq_clr_i) |=> flag);

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  // R8
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> count_o == $past(cnt));

  // R8
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(count_o));

  // R11
  oneshot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode_q == MODE_ONESHOT) |-> !sqw_o);

  // R4
  wave_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode_q == MODE_PERIODIC && !stop_i && !start_i && cnt == CNT_W'(1))
      |=> sqw_o != $past(sqw_o));
endmodule

bind dual_mode_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .rd_i      (rd_i),
  .irq_clr_i (irq_clr_i),
  .irq_en_i  (irq_en_i),
  .count_o   (count_o),
  .irq_o     (irq_o),
  .sqw_o     (sqw_o),
  .cnt       (cnt),
  .flag      (flag),
  .run       (run),
  .mode_q    (mode_q)
);

// File: tb/dual_mode_timer_tb_top.sv
`timescale 1ns/1ps
module dual_mode_timer_tb_top;
  localparam int W = 8;
  localparam int FULL = 1 << W;

  typedef struct {
    string      req;
    logic [W-1:0] cnt;
    logic       irq;
    logic       sqw;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pre_we_i = 1'b0;
  logic [W-1:0] pre_val_i = '0;
  logic         mode_i = 1'b0;
  logic         start_i = 1'b0;
  logic         stop_i = 1'b0;
  logic         irq_en_i = 1'b0;
  logic         irq_clr_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [W-1:0] count_o;
  logic         irq_o;
  logic         sqw_o;

  int checks = 0;
  int fails = 0;
  int k = 0;
  int per = 1;
  logic cur_mode = 1'b0;
  item_t exp_q[$];

  always #10 clk_i = ~clk_i;

  dual_mode_timer #(.CNT_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_we_i(pre_we_i), .pre_val_i(pre_val_i),
    .mode_i(mode_i), .start_i(start_i), .stop_i(stop_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .rd_i(rd_i), .count_o(count_o), .irq_o(irq_o), .sqw_o(sqw_o)
  );

  function automatic logic [W-1:0] mcnt(int j);
    if (cur_mode) return W'(per - (j % per));
    return W'(per - j);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(int n);
    repeat (n) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  task automatic do_start(int pre, logic m);
    pre_we_i = 1'b1; pre_val_i = W'(pre);
    adv(1);
    pre_we_i = 1'b0; mode_i = m; start_i = 1'b1; irq_clr_i = 1'b1;
    adv(1);
    start_i = 1'b0; irq_clr_i = 1'b0;
    k = 0; per = (pre == 0) ? FULL : pre; cur_mode = m;
  endtask

  task automatic read_exp(string req, logic [W-1:0] c, logic i, logic s);
    item_t it;
    it.req = req; it.cnt = c; it.irq = i; it.sqw = s;
    exp_q.push_back(it);
    rd_i = 1'b1;
    adv(1);
    rd_i = 1'b0;
  endtask

  // expectation from elapsed clocks since the start edge
  task automatic read_model(string req);
    logic i, s;
    i = ((k + 1) >= per) && irq_en_i;
    s = cur_mode ? logic'(((k + 1) / per) % 2) : 1'b0;
    read_exp(req, mcnt(k), i, s);
  endtask

  task automatic wait_toggle(output int n);
    logic last;
    last = sqw_o; n = 0;
    do begin
      @(negedge clk_i);
      k++; n++;
    end while (sqw_o == last && n < 1000);
  endtask

  // scoreboard monitor
  always begin
    @(posedge clk_i);
    if (rd_i && rst_ni) begin
      @(negedge clk_i);
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: actual=unexpected read expected=queued item");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (count_o !== it.cnt || irq_o !== it.irq || sqw_o !== it.sqw) begin
          fails++;
          $display("FAIL %s: actual cnt=%0d irq=%0b sqw=%0b expected cnt=%0d irq=%0b sqw=%0b",
                   it.req, count_o, irq_o, sqw_o, it.cnt, it.irq, it.sqw);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int gap;
    logic [W-1:0] fz;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    adv(1);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 sqw", int'(sqw_o), 0);

    irq_en_i = 1'b1;
    // R2, R3, R11: one-shot preload 5
    do_start(5, 1'b0);
    read_model("R2 load");
    adv(2);
    read_model("R2 dec");
    read_model("R3 terminal");
    read_model("R3 zero");
    read_model("R3 wrap R11");
    adv(3);
    chk("R8 hold", int'(count_o), 255);

    // R6 stop freezes, stop beats start
    fz = mcnt(k);
    stop_i = 1'b1;
    adv(1);
    stop_i = 1'b0;
    adv(4);
    read_exp("R6 frozen", fz, 1'b1, 1'b0);
    stop_i = 1'b1; start_i = 1'b1;
    adv(1);
    stop_i = 1'b0; start_i = 1'b0;
    adv(2);
    read_exp("R6 stop_wins", fz, 1'b1, 1'b0);

    // R7 mask, hold, clear
    irq_en_i = 1'b0;
    #1 chk("R7 masked", int'(irq_o), 0);
    adv(2);
    irq_en_i = 1'b1;
    #1 chk("R7 held", int'(irq_o), 1);
    irq_clr_i = 1'b1;
    adv(1);
    irq_clr_i = 1'b0;
    chk("R7 cleared", int'(irq_o), 0);

    // R4 periodic preload 3
    do_start(3, 1'b1);
    for (int i = 0; i < 8; i++) read_model("R4 periodic");
    wait_toggle(gap);
    wait_toggle(gap);
    chk("R4 half_period", gap, 3);

    // R7 set wins over clear
    do_start(1, 1'b1);
    irq_clr_i = 1'b1;
    adv(3);
    chk("R7 set_wins", int'(irq_o), 1);
    irq_clr_i = 1'b0;

    // R9, R10: preload write and mode change while running
    do_start(4, 1'b1);
    adv(2);
    pre_we_i = 1'b1; pre_val_i = W'(6); mode_i = 1'b0;
    adv(1);
    pre_we_i = 1'b0;
    read_model("R9 count_kept");
    wait_toggle(gap);
    wait_toggle(gap);
    chk("R9 new_period", gap, 6);
    wait_toggle(gap);
    chk("R10 mode_ignored", gap, 6);

    // R5 zero preload
    do_start(0, 1'b1);
    wait_toggle(gap);
    chk("R5 periodic_zero", gap, FULL);
    do_start(0, 1'b0);
    read_model("R5 oneshot_zero_load");
    adv(250);
    read_model("R5 oneshot_zero_mid");
    adv(255 - k);
    read_model("R5 oneshot_zero_term");
    adv(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule